// File: doc/BRIEF.md
# Synchronous Serial Byte Port

This block moves bytes between a host register port and a four-wire serial link: a bit clock, a frame-sync line, a receive data line and a transmit data line with its own output enable. Each direction has a 16-entry FIFO. Bytes go out and come in MSB first. Consecutive bytes follow each other with no spare bit clocks between them. A new byte is announced by a one-bit-wide frame-sync pulse that falls on the last bit (D0) of the byte before it, or on a lone lead-in bit when a burst begins.

As master, the port makes the bit clock by dividing the system clock, and it makes the frame-sync pulse itself. While it is enabled it frames a byte every eight bit clocks, without a break. As slave, it takes both lines from outside and edge-detects them in the system clock domain. In slave mode the outside clock may stop low between bursts. The host sees two sticky error flags, each cleared by its own action, and two FIFO-level interrupt outputs. It fills the transmit FIFO and drains the receive FIFO through a 2-bit register address.

Top module: `sbyte_port`

## Requirements
- R1: Bytes are shifted MSB first. While frame-sync pulses keep arriving on D0, bytes follow back to back, and `txd_oe` stays high from the first bit of the burst to the last bit of the final byte.
- R2: Frame sync is one bit period wide and marks the bit period just before a byte's MSB. As master, `fs_out` repeats every 8 bit periods (8*2*DIV_HALF system clocks) while enabled.
- R3: `txd` changes only when the bit clock rises. `rxd` and the frame-sync input are sampled when the bit clock falls.
- R4: `txd_oe` is low whenever no byte is being shifted out: while disabled, before the first frame of a burst, and after the last byte of a burst.
- R5: In slave mode the bit clock may stay low for any time between bursts. A burst that resumes after at least one clock before its frame-sync pulse transfers bytes exactly as the first burst did.
- R6: As master, `sclk_out` toggles every DIV_HALF system clocks without pause while enabled. It is held low while the port is disabled or in slave mode.
- R7: A byte that arrives when the receive FIFO holds 16 bytes is dropped and the stored bytes are kept. Status bit 0 then goes high and stays high through FIFO reads and data writes. Only a write to address 3 clears it.
- R8: A frame that starts with the transmit FIFO empty is sent as all ones and sets status bit 1. A write to address 0 clears that bit.
- R9: `rx_irq` is high when the receive FIFO holds at least 8 bytes. `tx_irq` is high when the transmit FIFO holds at most 8 bytes.
- R10: Register map:
  - Address 0: a write pushes to the TX FIFO, and a read with `reg_rd` pops the RX FIFO.
  - Address 1: control. Bit 0 is enable and bit 1 is master.
  - Address 2: status. Bit 0 is overrun, bit 1 is underrun, bit 2 is receive-not-empty and bit 3 is transmit-full.
  - After reset, control and status read 0, `txd_oe`, `sclk_out`, `fs_out` and `rx_irq` are 0, and `tx_irq` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RX FIFO at address 0) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from `reg_addr` |
| sclk_in | input | 1 | Bit clock from the link master (slave mode) |
| sclk_out | output | 1 | Bit clock driven in master mode |
| fs_in | input | 1 | Frame sync from the link master (slave mode) |
| fs_out | output | 1 | Frame sync driven in master mode |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data |
| txd_oe | output | 1 | Transmit output enable; low means the pin floats |
| rx_irq | output | 1 | Receive FIFO service request |
| tx_irq | output | 1 | Transmit FIFO service request |

## Verification
A bit counter or frame flag that has slipped shows on the pins within one frame. Either the looped-back byte comes back rotated, or `txd_oe` drops for a bit period in the middle of a burst. A frame-sync generator that is out of step shows up as a pulse spacing other than 64 system clocks, which is visible from the second pulse onwards. A wrong flag or FIFO level shows at the next status read or on the interrupt pins. A dropped or duplicated FIFO entry shows when the host drains the receive FIFO.

// File: rtl/sbyte_pkg.sv
package sbyte_pkg;

   typedef enum logic [1:0] {
      SEL_DATA = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_STAT = 2'd2,
      SEL_CLR  = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic master;
      logic enable;
   } port_ctrl_t;

endpackage

// File: rtl/sbyte_fifo.sv
module sbyte_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [WIDTH-1:0]           din,
   input  logic                       pop,
   output logic [WIDTH-1:0]           dout,
   output logic [$clog2(DEPTH):0]     level,
   output logic                       full,
   output logic                       empty
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sbyte_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] store [DEPTH];
   logic [AW-1:0]    wptr, rptr;
   logic [CW-1:0]    cnt;
   logic             do_push, do_pop;

   assign full    = (cnt == CW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = store[rptr];
   assign level   = cnt;

   always_ff @(posedge clk) begin
      if (do_push) store[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_push) wptr <= wptr + 1'b1;
         if (do_pop)  rptr <= rptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   // R7: a push into a full FIFO leaves the contents untouched
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (full && $stable(wptr)));

   // R8: popping an empty FIFO never moves the read side
   assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> (empty && $stable(rptr)));

endmodule

// File: rtl/sbyte_clkgen.sv
module sbyte_clkgen #(
   parameter int DIV_HALF    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int BITS        = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic master,
   input  logic sclk_in,
   input  logic fs_in,
   input  logic rxd_in,
   output logic sclk_out,
   output logic fs_out,
   output logic rise_o,
   output logic fall_o,
   output logic fs_o,
   output logic rxd_o
);
   localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
   localparam int FW = $clog2(BITS);
   localparam logic [FW-1:0] FLAST = FW'(BITS - 1);
   localparam logic [FW-1:0] FIDLE = FW'(BITS - 2);

   generate
      if (DIV_HALF < SYNC_STAGES + 1) begin : g_bad_div
         $error("sbyte_clkgen: DIV_HALF must exceed the synchronizer depth");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("sbyte_clkgen: SYNC_STAGES must be at least 2");
      end
   endgenerate

   // ---------------- input synchronizer: {sclk, fs, rxd} ----------------
   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      logic [2:0] d;
      logic [2:0] q;
      if (i == 0) begin : g_head
         assign d = {sclk_in, fs_in, rxd_in};
      end else begin : g_link
         assign d = g_stage[i-1].q;
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end
   end

   logic [2:0] sync_q;
   logic       sclk_d;
   assign sync_q = g_stage[SYNC_STAGES-1].q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sync_q[2];
   end

   // ---------------- master divider and framer ----------------
   logic          m_on, tick;
   logic [DW-1:0] dcnt;
   logic          sclk_q;
   logic [FW-1:0] fcnt;
   logic          m_rise, m_fall, s_rise, s_fall, s_on;

   assign m_on   = en && master;
   assign s_on   = en && !master;
   assign tick   = m_on && (dcnt == DW'(DIV_HALF - 1));
   assign m_rise = tick && !sclk_q;
   assign m_fall = tick && sclk_q;
   assign s_rise = s_on && sync_q[2] && !sclk_d;
   assign s_fall = s_on && !sync_q[2] && sclk_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt   <= '0;
         sclk_q <= 1'b0;
         fcnt   <= FIDLE;
      end else if (!m_on) begin
         dcnt   <= '0;
         sclk_q <= 1'b0;
         fcnt   <= FIDLE;
      end else begin
         dcnt <= tick ? '0 : dcnt + 1'b1;
         if (tick)   sclk_q <= !sclk_q;
         if (m_rise) fcnt   <= fcnt + 1'b1;
      end
   end

   assign sclk_out = sclk_q;
   assign fs_out   = m_on && (fcnt == FLAST);
   assign rise_o   = m_rise || s_rise;
   assign fall_o   = m_fall || s_fall;
   assign fs_o     = master ? fs_out : sync_q[1];
   assign rxd_o    = sync_q[0];

   // R2: a master frame-sync pulse ends at the next rising bit clock
   assert_fs_one_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (m_on && fs_out && rise_o) |=> !fs_out);

   // R6: the master clock is parked low when not running as master
   assert_sclk_parked_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !m_on |=> !sclk_out);

   // R6: while running, the master clock moves only on divider ticks
   assert_sclk_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (m_on && !tick) |=> $stable(sclk_out));

endmodule

// File: rtl/sbyte_shifter.sv
module sbyte_shifter #(
   parameter int BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            rise,
   input  logic            fall,
   input  logic            fs,
   input  logic            rxd,
   input  logic            tx_empty,
   input  logic [BITS-1:0] tx_data,
   output logic            tx_pop,
   output logic            underrun_evt,
   output logic            txd,
   output logic            txd_oe,
   output logic            rx_push,
   output logic [BITS-1:0] rx_data
);
   localparam int CNTW = $clog2(BITS);
   localparam logic [CNTW-1:0] LAST = CNTW'(BITS - 1);

   generate
      if (BITS < 2 || (BITS & (BITS - 1)) != 0) begin : g_bad_bits
         $error("sbyte_shifter: BITS must be a power of two");
      end
   endgenerate

   logic            fs_seen;
   logic [BITS-1:0] tx_sh;
   logic [CNTW-1:0] tx_cnt;
   logic            tx_act;
   logic [BITS-1:0] rx_sh;
   logic [CNTW-1:0] rx_cnt;
   logic            rx_act;
   logic            start;

   assign start        = en && rise && fs_seen;
   assign tx_pop       = start && !tx_empty;
   assign underrun_evt = start && tx_empty;
   assign rx_data      = {rx_sh[BITS-2:0], rxd};
   assign rx_push      = en && fall && rx_act && (rx_cnt == LAST);
   assign txd          = tx_sh[BITS-1];
   assign txd_oe       = tx_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_seen <= 1'b0;
         tx_sh   <= '0;
         tx_cnt  <= '0;
         tx_act  <= 1'b0;
         rx_sh   <= '0;
         rx_cnt  <= '0;
         rx_act  <= 1'b0;
      end else if (!en) begin
         fs_seen <= 1'b0;
         tx_sh   <= '0;
         tx_cnt  <= '0;
         tx_act  <= 1'b0;
         rx_sh   <= '0;
         rx_cnt  <= '0;
         rx_act  <= 1'b0;
      end else begin
         // transmit side: launch on the rising bit clock
         if (rise) begin
            if (fs_seen) begin
               tx_act <= 1'b1;
               tx_cnt <= '0;
               tx_sh  <= tx_empty ? '1 : tx_data;
            end else if (tx_act) begin
               if (tx_cnt == LAST) begin
                  tx_act <= 1'b0;
               end else begin
                  tx_cnt <= tx_cnt + 1'b1;
                  tx_sh  <= {tx_sh[BITS-2:0], 1'b1};
               end
            end
         end
         // receive side and frame detection: sample on the falling bit clock
         if (fall) begin
            fs_seen <= fs;
            if (rx_act) begin
               rx_sh  <= rx_data;
               rx_cnt <= rx_cnt + 1'b1;
            end
            if (fs) begin
               rx_act <= 1'b1;
               rx_cnt <= '0;
            end else if (rx_act && rx_cnt == LAST) begin
               rx_act <= 1'b0;
            end
         end
      end
   end

   // R3: the serial output holds between rising bit-clock events
   assert_txd_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !rise) |=> ($stable(txd) && $stable(txd_oe)));

   // R4: a disabled port releases the transmit pin
   assert_oe_released_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !txd_oe);

   // R1: a completed receive byte is handed over only on a falling bit clock
   assert_rx_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> (fall && !rise));

endmodule

// File: rtl/sbyte_port.sv
module sbyte_port
   import sbyte_pkg::*;
#(
   parameter int DEPTH       = 16,
   parameter int DIV_HALF    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] reg_addr,
   input  logic       reg_wr,
   input  logic       reg_rd,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata,
   input  logic       sclk_in,
   output logic       sclk_out,
   input  logic       fs_in,
   output logic       fs_out,
   input  logic       rxd,
   output logic       txd,
   output logic       txd_oe,
   output logic       rx_irq,
   output logic       tx_irq
);
   localparam int BITS = 8;
   localparam int CW   = $clog2(DEPTH) + 1;
   localparam logic [CW-1:0] HALF = CW'(DEPTH / 2);

   reg_sel_e   sel;
   port_ctrl_t ctrl;
   logic       ovr_flag, und_flag;
   logic       wr_data, rd_data, wr_ctrl, wr_clr;

   assign sel     = reg_sel_e'(reg_addr);
   assign wr_data = reg_wr && (sel == SEL_DATA);
   assign rd_data = reg_rd && (sel == SEL_DATA);
   assign wr_ctrl = reg_wr && (sel == SEL_CTRL);
   assign wr_clr  = reg_wr && (sel == SEL_CLR);

   logic unused_wdata;
   assign unused_wdata = ^reg_wdata[7:2];

   // ---------------- FIFOs ----------------
   logic [BITS-1:0] tx_head, rx_head, rx_word;
   logic [CW-1:0]   tx_level, rx_level;
   logic            tx_full, tx_empty, rx_full, rx_empty;
   logic            tx_pop, rx_push, und_evt;

   sbyte_fifo #(.WIDTH(BITS), .DEPTH(DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push(wr_data), .din(reg_wdata), .pop(tx_pop), .dout(tx_head),
      .level(tx_level), .full(tx_full), .empty(tx_empty)
   );

   sbyte_fifo #(.WIDTH(BITS), .DEPTH(DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push), .din(rx_word), .pop(rd_data), .dout(rx_head),
      .level(rx_level), .full(rx_full), .empty(rx_empty)
   );

   // ---------------- bit clock, framing, synchronizer ----------------
   logic rise, fall, fs_int, rxd_int;

   sbyte_clkgen #(.DIV_HALF(DIV_HALF), .SYNC_STAGES(SYNC_STAGES), .BITS(BITS)) u_clk (
      .clk(clk), .rst_n(rst_n), .en(ctrl.enable), .master(ctrl.master),
      .sclk_in(sclk_in), .fs_in(fs_in), .rxd_in(rxd),
      .sclk_out(sclk_out), .fs_out(fs_out),
      .rise_o(rise), .fall_o(fall), .fs_o(fs_int), .rxd_o(rxd_int)
   );

   sbyte_shifter #(.BITS(BITS)) u_shf (
      .clk(clk), .rst_n(rst_n), .en(ctrl.enable),
      .rise(rise), .fall(fall), .fs(fs_int), .rxd(rxd_int),
      .tx_empty(tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
      .underrun_evt(und_evt), .txd(txd), .txd_oe(txd_oe),
      .rx_push(rx_push), .rx_data(rx_word)
   );

   // ---------------- control and sticky flags ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl     <= '0;
         ovr_flag <= 1'b0;
         und_flag <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl <= port_ctrl_t'(reg_wdata[1:0]);
         // overrun: a fresh loss outranks a simultaneous clear
         if (rx_push && rx_full) ovr_flag <= 1'b1;
         else if (wr_clr)        ovr_flag <= 1'b0;
         // underrun: arriving data outranks a simultaneous empty frame
         if (wr_data)            und_flag <= 1'b0;
         else if (und_evt)       und_flag <= 1'b1;
      end
   end

   always_comb begin
      unique case (sel)
         SEL_DATA: reg_rdata = rx_head;
         SEL_CTRL: reg_rdata = {6'b0, ctrl};
         SEL_STAT: reg_rdata = {4'b0, tx_full, !rx_empty, und_flag, ovr_flag};
         default:  reg_rdata = 8'h00;
      endcase
   end

   assign rx_irq = (rx_level >= HALF);
   assign tx_irq = (tx_level <= HALF);

   // R7: the overrun flag only falls after a write to the clear address
   assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag && !wr_clr) |=> ovr_flag);

   // R8: writing transmit data always leaves the underrun flag low
   assert_underrun_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> !und_flag);

   // R9: a receive request implies stored data
   assert_rx_irq_backed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |-> !rx_empty);

endmodule

// File: tb/sbyte_port_test.sv
module sbyte_port_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       sclk_in = 1'b0;
   logic       fs_in = 1'b0;
   logic       rxd_drv = 1'b1;
   logic       loop_on = 1'b0;
   logic       sclk_out, fs_out, txd, txd_oe, rx_irq, tx_irq;
   logic       rxd_w;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   assign rxd_w = loop_on ? (txd_oe ? txd : 1'b1) : rxd_drv;

   always #5 clk = ~clk;

   sbyte_port uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sclk_in(sclk_in), .sclk_out(sclk_out), .fs_in(fs_in), .fs_out(fs_out),
      .rxd(rxd_w), .txd(txd), .txd_oe(txd_oe), .rx_irq(rx_irq), .tx_irq(tx_irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   // one slave bit period: 8 clocks high, 8 low; txd sampled at period end
   task automatic sbit(input logic f, input logic d, output logic t, output logic oe);
      sclk_in = 1'b1; fs_in = f; rxd_drv = d;
      repeat (8) @(negedge clk);
      sclk_in = 1'b0;
      repeat (7) @(negedge clk);
      t = txd; oe = txd_oe;
      @(negedge clk);
   endtask

   // ---------------- monitors for the master run ----------------
   logic mon_on = 1'b0;
   int   edge_bad = 0, gap_bad = 0, fs_bad = 0, fs_pulses = 0;
   logic oe_seen = 1'b0, txd_p = 1'b0, sclk_p = 1'b0, fs_p = 1'b0;
   int   fs_last = 0, fs_width = 0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (mon_on) begin
         if (txd !== txd_p && !(sclk_out && !sclk_p)) edge_bad++;
         if (txd_oe) oe_seen = 1'b1;
         else if (oe_seen) gap_bad++;
         if (fs_out && !fs_p) begin
            if (fs_pulses > 0 && (cyc - fs_last) != 64) fs_bad++;
            fs_last = cyc;
            fs_pulses++;
            fs_width = 0;
         end
         if (fs_out) fs_width++;
         if (!fs_out && fs_p && fs_width != 8) fs_bad++;
      end
      txd_p  = txd;
      sclk_p = sclk_out;
      fs_p   = fs_out;
   end

   // ---------------- watchdog ----------------
   initial begin
      wait (cyc >= 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   // {sent byte, expected received byte} for the master loopback run
   localparam logic [15:0] VEC [9] = '{
      16'hA5A5, 16'h3C3C, 16'h0000, 16'hFFFF, 16'h8181,
      16'h7E7E, 16'h5A5A, 16'hC3C3, 16'h9696
   };

   initial begin
      logic [7:0] v;
      logic [7:0] tb_byte;
      logic       t, oe, oe_all;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // ---- reset state (R10) ----
      rd(2'd1, v); check("R10 control after reset", v, 8'h00);
      rd(2'd2, v); check("R10 status after reset", v, 8'h00);
      check("R10 txd_oe after reset", txd_oe, 1'b0);
      check("R10 sclk_out after reset", sclk_out, 1'b0);
      check("R10 fs_out after reset", fs_out, 1'b0);
      check("R10 rx_irq after reset", rx_irq, 1'b0);
      check("R10 tx_irq after reset", tx_irq, 1'b1);

      // ---- vector table: master loopback (R1, R2, R3, R9) ----
      loop_on = 1'b1;
      for (int i = 0; i < 9; i++) begin
         wr(2'd0, VEC[i][15:8]);
         if (i == 7) check("R9 tx_irq at 8 entries", tx_irq, 1'b1);
         if (i == 8) check("R9 tx_irq at 9 entries", tx_irq, 1'b0);
      end
      wr(2'd1, 8'h03);
      mon_on = 1'b1;
      repeat (77 * 8 - 8) @(negedge clk);
      mon_on = 1'b0;
      check("R6 master clock ran", sclk_out | sclk_p | (fs_pulses > 0), 1'b1);
      repeat (8) @(negedge clk);
      rd(2'd2, v); check("R8 underrun after TX FIFO ran dry", v[1], 1'b1);
      wr(2'd1, 8'h00);
      @(negedge clk);
      check("R4 txd_oe released on disable", txd_oe, 1'b0);
      check("R6 sclk_out low on disable", sclk_out, 1'b0);
      check("R3 txd moves only on rising bit clock", edge_bad, 0);
      check("R1 no gap inside back-to-back burst", gap_bad, 0);
      check("R2 fs_out width and spacing", fs_bad, 0);
      check("R2 fs_out pulse count", (fs_pulses >= 9), 1'b1);
      for (int i = 0; i < 9; i++) begin
         rd(2'd0, v);
         check($sformatf("R1 loopback byte %0d", i), v, VEC[i][7:0]);
      end
      rd(2'd2, v); check("R10 RX empty after drain", v[2], 1'b0);
      loop_on = 1'b0;

      // ---- slave mode, gated clock, D0-aligned frame sync (R1-R5, R8) ----
      wr(2'd1, 8'h01);
      wr(2'd0, 8'hA5);
      wr(2'd0, 8'h5A);
      repeat (20) @(negedge clk);
      check("R6 sclk_out quiet in slave mode", sclk_out, 1'b0);
      check("R4 txd_oe low before first frame", txd_oe, 1'b0);
      sbit(1'b1, 1'b1, t, oe);
      check("R4 txd_oe low during lead-in period", oe, 1'b0);
      tb_byte = 8'h00; oe_all = 1'b1;
      for (int b = 7; b >= 0; b--) begin
         sbit(b == 0, 8'h3C >> b, t, oe);
         tb_byte[b] = t; oe_all &= oe;
      end
      check("R1 slave TX first byte MSB first", tb_byte, 8'hA5);
      for (int b = 7; b >= 0; b--) begin
         sbit(1'b0, 8'h81 >> b, t, oe);
         tb_byte[b] = t; oe_all &= oe;
      end
      check("R2 byte after D0 sync follows without gap", tb_byte, 8'h5A);
      check("R1 txd_oe held across both bytes", oe_all, 1'b1);
      sbit(1'b0, 1'b1, t, oe);
      check("R4 txd_oe low after last byte", oe, 1'b0);
      repeat (40) @(negedge clk);
      check("R5 txd_oe low while clock gated", txd_oe, 1'b0);
      rd(2'd0, v); check("R3 slave RX byte 1", v, 8'h3C);
      rd(2'd0, v); check("R3 slave RX byte 2", v, 8'h81);
      rd(2'd2, v); check("R8 no underrun yet", v[1], 1'b0);
      // second burst after the idle clock gap, TX FIFO empty
      sbit(1'b0, 1'b1, t, oe);
      sbit(1'b1, 1'b1, t, oe);
      for (int b = 7; b >= 0; b--) begin
         sbit(1'b0, 8'hC3 >> b, t, oe);
         tb_byte[b] = t;
      end
      check("R8 empty frame shifted as ones", tb_byte, 8'hFF);
      sbit(1'b0, 1'b1, t, oe);
      rd(2'd0, v); check("R5 RX after resumed clock", v, 8'hC3);
      rd(2'd2, v); check("R8 underrun flag set", v[1], 1'b1);
      wr(2'd0, 8'h00);
      rd(2'd2, v); check("R8 underrun cleared by TX write", v[1], 1'b0);
      wr(2'd1, 8'h00);

      // ---- overrun in master loopback (R7, R9) ----
      loop_on = 1'b1;
      wr(2'd0, 8'h22);
      wr(2'd1, 8'h03);
      repeat (170 * 8) @(negedge clk);
      wr(2'd1, 8'h00);
      loop_on = 1'b0;
      rd(2'd2, v); check("R7 overrun flag set", v[0], 1'b1);
      for (int i = 0; i < 16; i++) begin
         if (i == 0) check("R9 rx_irq at 16 entries", rx_irq, 1'b1);
         if (i == 8) check("R9 rx_irq at 8 entries", rx_irq, 1'b1);
         if (i == 9) check("R9 rx_irq at 7 entries", rx_irq, 1'b0);
         rd(2'd0, v);
         if (i == 0) check("R7 oldest byte kept", v, 8'h00);
         else if (i == 1) check("R7 second byte kept", v, 8'h22);
         else if (i == 15) check("R8 ones fill kept", v, 8'hFF);
      end
      rd(2'd2, v); check("R7 FIFO held exactly 16", v[2], 1'b0);
      check("R7 flag sticky after reads", v[0], 1'b1);
      wr(2'd0, 8'h77);
      rd(2'd2, v); check("R7 data write leaves overrun", v[0], 1'b1);
      check("R8 data write clears underrun", v[1], 1'b0);
      wr(2'd3, 8'h00);
      rd(2'd2, v); check("R7 clear address drops overrun", v[0], 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule